// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Register Group

This block holds the interrupt registers of a DMA engine and sits on a 32-bit register bus that uses word accesses. Seven hardware event sources each deliver one-cycle pulses. Every pulse sets a sticky status bit. The status bit is set whatever the mask holds. Software acknowledges an event by writing a 1 to its status bit.

Software cannot write the mask directly. It changes the mask only through two command registers. A 1 written to the enable register clears the matching mask bit, which unmasks that source. A 1 written to the disable register sets the matching mask bit, which masks that source. Any write to the disable register also discards every pending status bit. A single level interrupt line is high while at least one set status bit is unmasked.

The register offsets are fixed: status 0x14, enable 0x18, disable 0x1C, mask 0x20. Only register bits 7:1 exist. Event input `evt_i[k]` drives register bit k+1. From bit 1 upward the sources are:
- bit 1: transfer done
- bit 2: write-response error
- bit 3: stream timeout
- bit 4: memory timeout
- bit 5: threshold hit
- bit 6: invalid bus access
- bit 7: FIFO overflow

Top module: `irq_setclr_top`

## Requirements
- R1: After reset the mask register reads 0x000000FE, which means every source is masked. The status register reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets status bit k+1 at the next clock edge, whether or not that source is masked. The bit then stays set.
- R3: A status bit is cleared by a write to offset 0x14 with a 1 in that bit position. A 0 in a bit position leaves that status bit unchanged. Bits 0 and 31:8 of the write data are ignored.
- R4: A 1 written to offset 0x18 clears the matching mask bit. A 0 leaves that mask bit unchanged.
- R5: A 1 written to offset 0x1C sets the matching mask bit. A 0 leaves that mask bit unchanged.
- R6: Any write to offset 0x1C clears the whole status register, even when the write data is 0.
- R7: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It follows the register state in the same cycle that the state changes, so unmasking a source whose status bit is already set raises `irq_o` at once.
- R8: When an event and a clear of the same status bit arrive in the same cycle, the event wins and the bit stays set. The clear can come from a status write or from a disable write.
- R9: Offset 0x20 is read-only, and writes to it have no effect. Reads of 0x18, 0x1C and of any unmapped offset return 0.
- R10: Read data appears on `rdata_o` in the cycle after `rd_en_i`. Bits 0 and 31:8 of the read data are 0. When no read is issued, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| evt_i | input | 7 | Event pulses; bit k drives register bit k+1 |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
A corrupted status or mask bit becomes visible on `irq_o` in the first cycle after the bad edge, but only when the two bits of that source disagree in a way that changes the OR. The bench therefore reads both registers back, so that a wrong bit shows on `rdata_o` one cycle after the read strobe. The stimulus covers the priority between an event and a clear landing in the same cycle, the disable write that wipes status, and the unmasking of a source that is already pending. These three cases are where a wrong update order would show only as a missing or stale interrupt.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;
  localparam logic [7:0] OFS_STATUS  = 8'h14;
  localparam logic [7:0] OFS_ENABLE  = 8'h18;
  localparam logic [7:0] OFS_DISABLE = 8'h1C;
  localparam logic [7:0] OFS_MASK    = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_DISABLE,
    SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/irq_setclr_decode.sv
module irq_setclr_decode
  import irq_setclr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFS_STATUS))       sel_o = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_ENABLE))  sel_o = SEL_ENABLE;
    else if (addr_i == ADDR_W'(OFS_DISABLE)) sel_o = SEL_DISABLE;
    else if (addr_i == ADDR_W'(OFS_MASK))    sel_o = SEL_MASK;
  end
endmodule

// File: rtl/irq_setclr_cell.sv
module irq_setclr_cell (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic sts_clr_i,
  input  logic msk_set_i,
  input  logic msk_clr_i,
  output logic sts_q,
  output logic msk_q,
  output logic pend_d
);
  logic sts_d;
  logic msk_d;

  // A new event beats a clear arriving in the same cycle.
  always_comb begin
    sts_d  = evt_i | (sts_q & ~sts_clr_i);
    msk_d  = msk_set_i | (msk_q & ~msk_clr_i);
    pend_d = sts_d & ~msk_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      msk_q <= 1'b1;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end
endmodule

// File: rtl/irq_setclr_rdmux.sv
module irq_setclr_rdmux
  import irq_setclr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 7,
  parameter int SRC_LSB = 1
) (
  input  reg_sel_e            sel_i,
  input  logic [NUM_SRC-1:0]  sts_i,
  input  logic [NUM_SRC-1:0]  msk_i,
  output logic [DATA_W-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_STATUS: rdata_o[SRC_LSB +: NUM_SRC] = sts_i;
      SEL_MASK:   rdata_o[SRC_LSB +: NUM_SRC] = msk_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_setclr_top.sv
module irq_setclr_top
  import irq_setclr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 7,
  parameter int SRC_LSB = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wfield;
  logic [NUM_SRC-1:0] sts_clr;
  logic [NUM_SRC-1:0] msk_set;
  logic [NUM_SRC-1:0] msk_clr;
  logic [NUM_SRC-1:0] sts_q;
  logic [NUM_SRC-1:0] msk_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [DATA_W-1:0]  rd_mux;
  logic               wr_sts;
  logic               wr_ena;
  logic               wr_dis;

  irq_setclr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  always_comb begin
    wfield  = wdata_i[SRC_LSB +: NUM_SRC];
    wr_sts  = wr_en_i && (sel == SEL_STATUS);
    wr_ena  = wr_en_i && (sel == SEL_ENABLE);
    wr_dis  = wr_en_i && (sel == SEL_DISABLE);
    sts_clr = (wr_sts ? wfield : '0) | {NUM_SRC{wr_dis}};
    msk_set = wr_dis ? wfield : '0;
    msk_clr = wr_ena ? wfield : '0;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    irq_setclr_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (evt_i[k]),
      .sts_clr_i (sts_clr[k]),
      .msk_set_i (msk_set[k]),
      .msk_clr_i (msk_clr[k]),
      .sts_q     (sts_q[k]),
      .msk_q     (msk_q[k]),
      .pend_d    (pend_d[k])
    );
  end

  irq_setclr_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC),
    .SRC_LSB (SRC_LSB)
  ) u_rd (
    .sel_i   (sel),
    .sts_i   (sts_q),
    .msk_i   (msk_q),
    .rdata_o (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      irq_o   <= |pend_d;
      rdata_o <= rd_en_i ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_setclr_chk.sv
module irq_setclr_chk
  import irq_setclr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 7,
  parameter int SRC_LSB = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] sts_q,
  input logic [NUM_SRC-1:0] msk_q
);
  logic [NUM_SRC-1:0] wf;
  assign wf = wdata_i[SRC_LSB +: NUM_SRC];

  a_r1_mask_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (&msk_q && sts_q == '0 && !irq_o));

  a_r4_enable_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(OFS_ENABLE)) |=> ((msk_q & $past(wf)) == '0));

  a_r5_disable_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(OFS_DISABLE)) |=> ((msk_q & $past(wf)) == $past(wf)));

  a_r6_disable_wipes: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(OFS_DISABLE)) |=> (sts_q == $past(evt_i)));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(sts_q & ~msk_q));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  a_r9_mask_readonly: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == ADDR_W'(OFS_MASK)) |=> $stable(msk_q));

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rdata_o == '0));
endmodule

bind irq_setclr_top irq_setclr_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .NUM_SRC (NUM_SRC),
  .SRC_LSB (SRC_LSB)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .evt_i   (evt_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .msk_q   (msk_q)
);

// File: tb/irq_setclr_top_tb_top.sv
module irq_setclr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [6:0]  evt_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_setclr_top dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .evt_i(evt_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {op[1:0] (0 idle,1 write,2 read), addr[7:0], wdata[7:0], evt[6:0], exp_irq, exp_rdata[7:0], req[3:0]}
  localparam int NV = 27;
  localparam logic [37:0] VEC [NV] = '{
    {2'd2, 8'h20, 8'h00, 7'h00, 1'b0, 8'hFE, 4'd1},  // R1 mask reset
    {2'd2, 8'h14, 8'h00, 7'h00, 1'b0, 8'h00, 4'd1},  // R1 status reset
    {2'd0, 8'h00, 8'h00, 7'h01, 1'b0, 8'h00, 4'd2},  // R2 masked event
    {2'd2, 8'h14, 8'h00, 7'h00, 1'b0, 8'h02, 4'd2},  // R2 latched
    {2'd1, 8'h18, 8'h02, 7'h00, 1'b1, 8'h00, 4'd7},  // R7 unmask pending
    {2'd2, 8'h20, 8'h00, 7'h00, 1'b1, 8'hFC, 4'd4},  // R4
    {2'd1, 8'h14, 8'h00, 7'h00, 1'b1, 8'h00, 4'd3},  // R3 zero no effect
    {2'd1, 8'h14, 8'h02, 7'h00, 1'b0, 8'h00, 4'd3},  // R3 clear
    {2'd1, 8'h14, 8'h02, 7'h01, 1'b1, 8'h00, 4'd8},  // R8 event beats clear
    {2'd1, 8'h20, 8'h00, 7'h00, 1'b1, 8'h00, 4'd9},  // R9 mask write
    {2'd2, 8'h20, 8'h00, 7'h00, 1'b1, 8'hFC, 4'd9},  // R9 mask kept
    {2'd2, 8'h18, 8'h00, 7'h00, 1'b1, 8'h00, 4'd9},  // R9 enable reads 0
    {2'd2, 8'h1C, 8'h00, 7'h00, 1'b1, 8'h00, 4'd9},  // R9 disable reads 0
    {2'd0, 8'h00, 8'h00, 7'h40, 1'b1, 8'h00, 4'd2},  // R2 bit7
    {2'd1, 8'h1C, 8'h00, 7'h00, 1'b0, 8'h00, 4'd6},  // R6 wipe on zero write
    {2'd2, 8'h20, 8'h00, 7'h00, 1'b0, 8'hFC, 4'd5},  // R5 zero no effect
    {2'd2, 8'h14, 8'h00, 7'h00, 1'b0, 8'h00, 4'd6},  // R6 status empty
    {2'd1, 8'h18, 8'hFE, 7'h00, 1'b0, 8'h00, 4'd4},  // R4 unmask all
    {2'd0, 8'h00, 8'h00, 7'h20, 1'b1, 8'h00, 4'd7},  // R7 bit6 fires
    {2'd1, 8'h1C, 8'h40, 7'h00, 1'b0, 8'h00, 4'd5},  // R5 mask bit6
    {2'd2, 8'h20, 8'h00, 7'h00, 1'b0, 8'h40, 4'd5},  // R5 readback
    {2'd0, 8'h00, 8'h00, 7'h10, 1'b1, 8'h00, 4'd7},  // R7 bit5
    {2'd1, 8'h1C, 8'h20, 7'h10, 1'b0, 8'h00, 4'd8},  // R8 event beats wipe
    {2'd2, 8'h14, 8'h00, 7'h00, 1'b0, 8'h20, 4'd8},  // R8 bit5 kept
    {2'd1, 8'h18, 8'h20, 7'h00, 1'b1, 8'h00, 4'd7},  // R7 unmask pending
    {2'd2, 8'h10, 8'h00, 7'h00, 1'b1, 8'h00, 4'd9},  // R9 unmapped
    {2'd1, 8'h14, 8'hFF, 7'h00, 1'b0, 8'h00, 4'd3}   // R3 clear all
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] a,
                      input logic [31:0] wd, input logic [6:0] ev);
    wr_en_i = (op == 2'd1);
    rd_en_i = (op == 2'd2);
    addr_i  = a;
    wdata_i = wd;
    evt_i   = ev;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
    rd_en_i = 1'b0;
    evt_i   = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][37:36], VEC[i][35:28], {24'd0, VEC[i][27:20]}, VEC[i][19:13]);
      check($sformatf("R%0d vec%0d irq", VEC[i][3:0], i), {31'd0, irq_o}, {31'd0, VEC[i][12]});
      check($sformatf("R%0d vec%0d rdata", VEC[i][3:0], i), rdata_o, {24'd0, VEC[i][11:4]});
    end
    // R10 full-width read with upper bits zero; mask is 0x40 here
    step(2'd0, 8'h00, 32'd0, 7'h7F);
    check("R2 all events irq", {31'd0, irq_o}, 32'd1);
    step(2'd2, 8'h14, 32'd0, 7'h00);
    check("R10 status full width", rdata_o, 32'h0000_00FE);
    step(2'd0, 8'h00, 32'd0, 7'h00);
    check("R10 idle read zero", rdata_o, 32'd0);
    // R3 upper write bits ignored: clear via wide write
    step(2'd1, 8'h14, 32'hFFFF_FF02, 7'h00);
    step(2'd2, 8'h14, 32'd0, 7'h00);
    check("R3 wide clear", rdata_o, 32'h0000_00FC);
    // R1 reset mid-operation
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after mid reset", {31'd0, irq_o}, 32'd0);
    step(2'd2, 8'h20, 32'd0, 7'h00);
    check("R1 mask after mid reset", rdata_o, 32'h0000_00FE);
    step(2'd2, 8'h14, 32'd0, 7'h00);
    check("R1 status after mid reset", rdata_o, 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule